// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition and Control Flags

This block executes one arithmetic or logic operation per clock on 8-bit or 16-bit operands. A per-operation width select chooses between byte and word. Each accepted operation can do three things on the next rising edge: update a registered result, update a 16-bit flag word, or both. The flag word carries six condition flags derived from the computation. It also carries three control flags, which only dedicated set and clear commands change.

A sequencer drives `opValid`, an operation code, the width select and two operands. It reads `result` and `flags` one cycle later. Add-with-carry and subtract-with-borrow take their carry-in from the stored carry flag, so multi-byte or multi-word arithmetic is chained by issuing successive operations. Compare only updates the flags. The direction flag tells the index stepping logic to count down when it is 1 and up when it is 0. The interrupt-enable flag gates interrupt acceptance elsewhere.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset `result` is 0x0000 and `flags` is 0x0002.
- R2: Flag word layout: carry bit 0, parity bit 2, auxiliary bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt-enable bit 9, direction bit 10, overflow bit 11. Bit 1 always reads 1 and every other bit reads 0.
- R3: The operation codes are ADD 0, ADC 1, SUB 2, SBB 3, CMP 4, AND 5, OR 6, XOR 7, NOT 8 (of srcA), INC 9, DEC 10, SHL 11 (of srcA), TSET 12, TCLR 13, ISET 14, ICLR 15, DSET 16 and DCLR 17. An operation accepted on a rising edge with `opValid` high shows its result and flags after that edge. With `wide` = 0 only the low bytes of the operands are used and the upper result byte is 0.
- R4: Carry is set on a carry out of the active width for ADD/ADC/INC and on a borrow for SUB/SBB/CMP/DEC. ADC and SBB add or subtract the stored carry as well.
- R5: Parity is 1 when the low result byte holds an even number of 1 bits, whatever the width.
- R6: Auxiliary is 1 when an add, subtract, increment, decrement or compare carries or borrows between bit 3 and bit 4.
- R7: Zero is 1 when the result at the active width is all zeros. Sign equals the result's top bit at the active width.
- R8: Overflow is 1 when the signed result of an add, subtract, increment, decrement or compare does not fit in the active width.
- R9: AND, OR, XOR and NOT clear carry and overflow, leave auxiliary unchanged, and update parity, zero and sign.
- R10: INC and DEC leave carry unchanged.
- R11: CMP updates the flags as SUB does but leaves `result` unchanged.
- R12: SHL shifts left by one. Carry receives the bit shifted out, overflow is the new top bit XOR carry, and auxiliary is unchanged.
- R13: TSET/TCLR, ISET/ICLR and DSET/DCLR set or clear the trap, interrupt-enable and direction flags. They change no other flag and do not change `result`. Arithmetic operations leave these three flags unchanged.
- R14: With `opValid` low, or with an unassigned operation code (18 to 31), neither `result` nor `flags` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Accept the operation on this edge |
| opCode | input | 5 | Operation code (see R3) |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| srcA | input | 16 | First operand |
| srcB | input | 16 | Second operand |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered flag word |

## Verification
On every cycle, the bound assertions check several relations. The fixed flag bits hold their values. The zero, sign and parity flags agree with the stored result after each result-writing operation. Logic operations clear carry and overflow. INC and DEC keep carry. Compare and idle cycles leave the result alone. Control commands land in the right bit. The exact carry, auxiliary and overflow values depend on operand values, so only the bench's scenarios show them. The same holds for carry chaining through ADC and SBB, for byte-mode masking of the upper operand bytes, and for unassigned codes being ignored.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int DATA_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int FLAG_W  = 16;

  localparam int CF_BIT  = 0;
  localparam int ONE_BIT = 1;
  localparam int PF_BIT  = 2;
  localparam int AF_BIT  = 4;
  localparam int ZF_BIT  = 6;
  localparam int SF_BIT  = 7;
  localparam int TF_BIT  = 8;
  localparam int IF_BIT  = 9;
  localparam int DF_BIT  = 10;
  localparam int OF_BIT  = 11;
  localparam int NIB_BIT = 4;

  localparam logic [FLAG_W-1:0] USED_MASK =
      FLAG_W'((1 << CF_BIT) | (1 << PF_BIT) | (1 << AF_BIT) | (1 << ZF_BIT) |
              (1 << SF_BIT) | (1 << TF_BIT) | (1 << IF_BIT) | (1 << DF_BIT) |
              (1 << OF_BIT));
  localparam logic [FLAG_W-1:0] FIXED_ONES = FLAG_W'(1 << ONE_BIT);

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBB  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_NOT  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_SHL  = 5'd11,
    OP_TSET = 5'd12, OP_TCLR = 5'd13, OP_ISET = 5'd14, OP_ICLR = 5'd15,
    OP_DSET = 5'd16, OP_DCLR = 5'd17
  } opCode_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOT, FN_SHL
  } aluFn_e;

  typedef enum logic [1:0] {
    UPD_KEEP, UPD_CALC, UPD_CLEAR
  } updMode_e;

  typedef enum logic [1:0] {
    CTL_TRAP, CTL_INTR, CTL_DIR
  } ctlSel_e;

  typedef struct packed {
    logic     wrResult;
    logic     wrStatus;
    aluFn_e   fn;
    logic     useCarry;
    logic     bIsOne;
    updMode_e cfMode;
    updMode_e ofMode;
    updMode_e afMode;
    logic     ctlWr;
    ctlSel_e  ctlSel;
    logic     ctlVal;
  } aluStrobe_t;

endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic       opValid,
  input  logic [4:0] opCode,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (opValid) begin
      case (opCode)
        OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP, OP_INC, OP_DEC: begin
          strobe.wrResult = (opCode != OP_CMP);
          strobe.wrStatus = 1'b1;
          strobe.fn       = (opCode == OP_ADD || opCode == OP_ADC ||
                             opCode == OP_INC) ? FN_ADD : FN_SUB;
          strobe.useCarry = (opCode == OP_ADC || opCode == OP_SBB);
          strobe.bIsOne   = (opCode == OP_INC || opCode == OP_DEC);
          strobe.cfMode   = (opCode == OP_INC || opCode == OP_DEC) ? UPD_KEEP : UPD_CALC;
          strobe.ofMode   = UPD_CALC;
          strobe.afMode   = UPD_CALC;
        end
        OP_AND, OP_OR, OP_XOR, OP_NOT: begin
          strobe.wrResult = 1'b1;
          strobe.wrStatus = 1'b1;
          strobe.fn       = (opCode == OP_AND) ? FN_AND :
                            (opCode == OP_OR)  ? FN_OR  :
                            (opCode == OP_XOR) ? FN_XOR : FN_NOT;
          strobe.cfMode   = UPD_CLEAR;
          strobe.ofMode   = UPD_CLEAR;
          strobe.afMode   = UPD_KEEP;
        end
        OP_SHL: begin
          strobe.wrResult = 1'b1;
          strobe.wrStatus = 1'b1;
          strobe.fn       = FN_SHL;
          strobe.cfMode   = UPD_CALC;
          strobe.ofMode   = UPD_CALC;
          strobe.afMode   = UPD_KEEP;
        end
        OP_TSET, OP_TCLR, OP_ISET, OP_ICLR, OP_DSET, OP_DCLR: begin
          strobe.ctlWr  = 1'b1;
          strobe.ctlSel = (opCode == OP_TSET || opCode == OP_TCLR) ? CTL_TRAP :
                          (opCode == OP_ISET || opCode == OP_ICLR) ? CTL_INTR : CTL_DIR;
          strobe.ctlVal = (opCode == OP_TSET || opCode == OP_ISET || opCode == OP_DSET);
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/alu_flag_dpath.sv
module alu_flag_dpath
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic              wide,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  localparam int RAW_W = DATA_W + 1;

  logic [DATA_W-1:0] opA, opB, resVal, resReg;
  logic [RAW_W-1:0]  sumRaw, difRaw, raw;
  logic [FLAG_W-1:0] flagReg, nextFlags;
  logic              carryIn, carryOut, msbA, msbB, msbR, ovf, auxC;

  always_comb begin
    opA = wide ? srcA : {{(DATA_W-BYTE_W){1'b0}}, srcA[BYTE_W-1:0]};
    if (strobe.bIsOne) opB = DATA_W'(1);
    else opB = wide ? srcB : {{(DATA_W-BYTE_W){1'b0}}, srcB[BYTE_W-1:0]};
    carryIn = strobe.useCarry & flagReg[CF_BIT];
    sumRaw  = {1'b0, opA} + {1'b0, opB} + RAW_W'(carryIn);
    difRaw  = {1'b0, opA} - {1'b0, opB} - RAW_W'(carryIn);
    case (strobe.fn)
      FN_ADD:  raw = sumRaw;
      FN_SUB:  raw = difRaw;
      FN_AND:  raw = {1'b0, opA & opB};
      FN_OR:   raw = {1'b0, opA | opB};
      FN_XOR:  raw = {1'b0, opA ^ opB};
      FN_NOT:  raw = {1'b0, ~opA};
      default: raw = {opA, 1'b0};
    endcase
    resVal   = wide ? raw[DATA_W-1:0] : {{(DATA_W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};
    carryOut = wide ? raw[DATA_W] : raw[BYTE_W];
    msbA     = wide ? opA[DATA_W-1] : opA[BYTE_W-1];
    msbB     = wide ? opB[DATA_W-1] : opB[BYTE_W-1];
    msbR     = wide ? resVal[DATA_W-1] : resVal[BYTE_W-1];
    auxC     = opA[NIB_BIT] ^ opB[NIB_BIT] ^ raw[NIB_BIT];
    case (strobe.fn)
      FN_ADD:  ovf = (msbA == msbB) && (msbR != msbA);
      FN_SUB:  ovf = (msbA != msbB) && (msbR != msbA);
      FN_SHL:  ovf = msbR ^ carryOut;
      default: ovf = 1'b0;
    endcase
  end

  always_comb begin
    nextFlags = flagReg;
    if (strobe.wrStatus) begin
      nextFlags[ZF_BIT] = (resVal == '0);
      nextFlags[SF_BIT] = msbR;
      nextFlags[PF_BIT] = ~^resVal[BYTE_W-1:0];
    end
    if (strobe.cfMode == UPD_CALC)       nextFlags[CF_BIT] = carryOut;
    else if (strobe.cfMode == UPD_CLEAR) nextFlags[CF_BIT] = 1'b0;
    if (strobe.ofMode == UPD_CALC)       nextFlags[OF_BIT] = ovf;
    else if (strobe.ofMode == UPD_CLEAR) nextFlags[OF_BIT] = 1'b0;
    if (strobe.afMode == UPD_CALC)       nextFlags[AF_BIT] = auxC;
    else if (strobe.afMode == UPD_CLEAR) nextFlags[AF_BIT] = 1'b0;
    if (strobe.ctlWr) begin
      case (strobe.ctlSel)
        CTL_TRAP: nextFlags[TF_BIT] = strobe.ctlVal;
        CTL_INTR: nextFlags[IF_BIT] = strobe.ctlVal;
        default:  nextFlags[DF_BIT] = strobe.ctlVal;
      endcase
    end
    nextFlags = (nextFlags & USED_MASK) | FIXED_ONES;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg  <= '0;
      flagReg <= FIXED_ONES;
    end else begin
      flagReg <= nextFlags;
      if (strobe.wrResult) resReg <= resVal;
    end
  end

  assign result = resReg;
  assign flags  = flagReg;

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [4:0]  opCode,
  input  logic        wide,
  input  logic [15:0] srcA,
  input  logic [15:0] srcB,
  output logic [15:0] result,
  output logic [15:0] flags
);

  aluStrobe_t strobe;

  alu_flag_ctrl i_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  alu_flag_dpath i_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wide   (wide),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result),
    .flags  (flags)
  );

endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk
  import alu_flag_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [4:0]  opCode,
  input logic        wide,
  input logic [15:0] result,
  input logic [15:0] flags
);

  logic wrOp, logicOp, stepOp;
  assign wrOp    = opValid && (opCode <= OP_SHL) && (opCode != OP_CMP);
  assign logicOp = opValid && (opCode >= OP_AND) && (opCode <= OP_NOT);
  assign stepOp  = opValid && (opCode == OP_INC || opCode == OP_DEC);

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    flags[ONE_BIT] && ((flags & ~(USED_MASK | FIXED_ONES)) == '0)); // R2

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wrOp |=> flags[ZF_BIT] == (($past(wide) ? result : {8'h00, result[7:0]}) == 16'h0)); // R7

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wrOp |=> flags[SF_BIT] == ($past(wide) ? result[15] : result[7])); // R7

  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wrOp |=> flags[PF_BIT] == ~^result[7:0]); // R5

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    logicOp |=> !flags[CF_BIT] && !flags[OF_BIT]); // R9

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    stepOp |=> flags[CF_BIT] == $past(flags[CF_BIT])); // R10

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |=> $stable(result)); // R11

  AST_DIR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_DSET) |=> flags[DF_BIT]); // R13

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flags) && $stable(result)); // R14

endmodule

bind alu_flag_unit alu_flag_chk i_alu_flag_chk (.*);

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic        wide = 1'b0;
  logic [15:0] srcA = '0, srcB = '0;
  logic [15:0] result, flags;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .wide(wide),
    .srcA(srcA), .srcB(srcB), .result(result), .flags(flags)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic        w;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic [15:0] flg;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{5'd0,  1'b0, 16'h007F, 16'h0001, 16'h0080, 16'h0892}, // R4 R6 R8 byte overflow
    '{5'd0,  1'b1, 16'hFFFF, 16'h0001, 16'h0000, 16'h0057}, // R4 R5 R7 word carry
    '{5'd1,  1'b0, 16'hFF10, 16'h0020, 16'h0031, 16'h0002}, // R3 R4 carry-in, high byte ignored
    '{5'd2,  1'b0, 16'h0000, 16'h0001, 16'h00FF, 16'h0097}, // R4 R6 borrow
    '{5'd3,  1'b1, 16'h8000, 16'h0000, 16'h7FFF, 16'h0816}, // R4 R8 borrow-in
    '{5'd4,  1'b1, 16'h1234, 16'h1234, 16'h7FFF, 16'h0046}, // R11 compare equal
    '{5'd9,  1'b0, 16'h000F, 16'h0000, 16'h0010, 16'h0012}, // R6 R10 inc
    '{5'd5,  1'b1, 16'hF0F0, 16'h0FF0, 16'h00F0, 16'h0016}, // R9 and
    '{5'd6,  1'b0, 16'h0080, 16'h0001, 16'h0081, 16'h0096}, // R9 or
    '{5'd7,  1'b1, 16'hAAAA, 16'hAAAA, 16'h0000, 16'h0056}, // R9 xor
    '{5'd8,  1'b0, 16'h000F, 16'h0000, 16'h00F0, 16'h0096}, // R9 not
    '{5'd11, 1'b1, 16'h8001, 16'h0000, 16'h0002, 16'h0813}, // R12 word shift
    '{5'd10, 1'b0, 16'h0000, 16'h0000, 16'h00FF, 16'h0097}, // R10 dec
    '{5'd9,  1'b1, 16'h7FFF, 16'h0000, 16'h8000, 16'h0897}, // R8 R10 inc overflow
    '{5'd11, 1'b0, 16'h0040, 16'h0000, 16'h0080, 16'h0892}, // R12 byte shift
    '{5'd0,  1'b1, 16'h8000, 16'h8000, 16'h0000, 16'h0847}, // R4 R8 word add
    '{5'd2,  1'b1, 16'h8000, 16'h0001, 16'h7FFF, 16'h0816}  // R6 R8 word sub
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic v, input logic [4:0] op, input logic w,
                      input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    opValid = v; opCode = op; wide = w; srcA = a; srcB = b;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 16'h0000);
    check("R1 R2 reset flags", flags, 16'h0002);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      doOp(1'b1, VECS[i].op, VECS[i].w, VECS[i].a, VECS[i].b);
      check($sformatf("R3 vector %0d result", i), result, VECS[i].res);
      check($sformatf("R3 vector %0d flags", i), flags, VECS[i].flg);
    end

    doOp(1'b1, 5'd12, 1'b0, 16'h0, 16'h0);
    check("R13 trap set flags", flags, 16'h0916);
    check("R13 trap set result", result, 16'h7FFF);
    doOp(1'b1, 5'd14, 1'b0, 16'h0, 16'h0);
    check("R13 intr set", flags, 16'h0B16);
    doOp(1'b1, 5'd16, 1'b0, 16'h0, 16'h0);
    check("R13 dir set", flags, 16'h0F16);
    doOp(1'b1, 5'd13, 1'b0, 16'h0, 16'h0);
    check("R13 trap clear", flags, 16'h0E16);
    doOp(1'b1, 5'd0, 1'b0, 16'h0001, 16'h0001);
    check("R13 add keeps control result", result, 16'h0002);
    check("R13 add keeps control flags", flags, 16'h0602);
    doOp(1'b0, 5'd2, 1'b1, 16'h0000, 16'h0001);
    check("R14 idle result", result, 16'h0002);
    check("R14 idle flags", flags, 16'h0602);
    doOp(1'b1, 5'd25, 1'b1, 16'h0000, 16'h0001);
    check("R14 unassigned result", result, 16'h0002);
    check("R14 unassigned flags", flags, 16'h0602);
    doOp(1'b1, 5'd17, 1'b0, 16'h0, 16'h0);
    check("R13 dir clear", flags, 16'h0202);
    doOp(1'b1, 5'd15, 1'b0, 16'h0, 16'h0);
    check("R13 intr clear", flags, 16'h0002);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule